// File: doc/BRIEF.md
# Region-Based Memory Access Permission Checker

This block decides whether a memory access may proceed. A request carries a start address, a byte count, a machine-mode flag and the operation it wants (read, write, execute). The block receives the inclusive bounds and configuration of every protection region, plus two global security controls: a lockdown mode and a deny-by-default mode. It returns the set of permissions granted, an allow/deny verdict, the index of the region that decided, and a flag for the case where no region and no default policy grants anything.

Regions are searched in ascending index order. The first and last bytes of the access are each tested against every region's bounds. The lowest-numbered enabled region that touches either byte decides the result. If that region covers only one of the two bytes, the access is denied. If it covers both, its configuration gives the permissions, through either the classic rule or the lockdown tables. When no region touches the access, a default policy applies. The result is registered and appears one clock after the request.

Top module: `pmp_perm_check`

## Requirements
- R1: The first byte `req_addr` and the last byte `req_addr+span-1` are tested against each enabled region's inclusive bounds `[lo, hi]`. The lowest-indexed enabled region that contains both bytes decides the result, and its index appears on `rsp_idx`.
- R2: If the lowest-indexed enabled region touching the access contains only one of the two bytes, the access is denied. The response then has `rsp_nomatch=1`, `rsp_perm=0` and `rsp_idx=0`, even if a higher region contains the whole access.
- R3: A `req_size` of zero is treated as a span of `WORD_BYTES` (default 4). Any other size is taken as the byte count.
- R4: Each region's 5-bit config is {enable[4], lock[3], R[2], W[1], X[0]}. With lockdown clear, a machine-mode access to an unlocked region is granted RWX. Otherwise the grant is the region's R, W and X bits.
- R5: With lockdown set, a machine-mode match is granted permissions from index {lock,R,W,X}. Index 2, 3 or 14 gives RW. Index 9 or 10 gives X. Index 11 or 13 gives RX. Index 12 or 15 gives R. Every remaining index gives nothing.
- R6: With lockdown set, a lower-mode match is granted permissions from index {lock,R,W,X}. Index 7 gives RWX. Index 3 or 6 gives RW. Index 5 gives RX. Index 2, 4 or 15 gives R. Index 1, 10 or 11 gives X. Every remaining index gives nothing.
- R7: With no matching region and `sec_deny_default=1`, every access is denied with `rsp_nomatch=1`.
- R8: With no matching region, lockdown set and deny-default clear, a machine-mode access that does not request X is granted RW with `rsp_idx=NUM_ENTRIES`. All other accesses are denied.
- R9: With no matching region and both security controls clear, a machine-mode access is granted RWX with `rsp_idx=NUM_ENTRIES`, and a lower-mode access is denied. When built with `HAS_PMP=0`, every mode is granted RWX this way.
- R10: Operation and permission vectors are {R[2], W[1], X[0]}. `rsp_allow` is 1 exactly when `rsp_nomatch` is 0 and every requested bit is present in `rsp_perm`.
- R11: The response registers load on the clock edge that samples `req_valid=1`, and `rsp_valid` is `req_valid` delayed by one cycle. Synchronous reset clears every response output to 0.
- R12: A region whose enable bit is 0 never matches and never causes a partial-overlap deny, whatever its bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Byte count, 0 meaning one machine word |
| req_mmode | input | 1 | 1 = machine mode, 0 = lower mode |
| req_op | input | 3 | Requested operation {R,W,X} |
| sec_lockdown | input | 1 | Lockdown permission tables enabled |
| sec_deny_default | input | 1 | Deny every unmatched access |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Packed inclusive lower bounds, region i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Packed inclusive upper bounds |
| ent_cfg | input | NUM_ENTRIES*5 | Packed region configs {en,lock,R,W,X} |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_perm | output | 3 | Granted permissions {R,W,X} |
| rsp_idx | output | IDX_W | Deciding region, or NUM_ENTRIES for a default grant |
| rsp_nomatch | output | 1 | Denied by partial overlap or by the default policy |

## Verification
The hardest condition to reach is a partial overlap at a low-numbered region while a higher region covers the whole access. The response must still be a deny, not the higher region's grant. The stimulus places two overlapping regions and issues an access that straddles the top of the lower one and lies wholly inside the upper one. A second straddle uses a zero size, so the word-length substitution alone moves the last byte out of range. A third access with a one-byte size at the same address shows the same region matching fully. The lockdown tables are swept exhaustively by rewriting one region's lock and permission bits through all sixteen values in both privilege modes.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int CFG_W = 5;
  localparam int CFG_EN = 4;
  localparam int CFG_LK = 3;

  typedef logic [2:0] perm_t;
  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b100;
  localparam perm_t P_X    = 3'b001;
  localparam perm_t P_RW   = 3'b110;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // Lockdown grant for machine mode, index {lock,R,W,X}
  function automatic perm_t lockdown_mach(input logic [3:0] k);
    case (k)
      4'd2, 4'd3, 4'd14: return P_RW;
      4'd9, 4'd10:       return P_X;
      4'd11, 4'd13:      return P_RX;
      4'd12, 4'd15:      return P_R;
      default:           return P_NONE;
    endcase
  endfunction

  // Lockdown grant for lower modes, index {lock,R,W,X}
  function automatic perm_t lockdown_low(input logic [3:0] k);
    case (k)
      4'd1, 4'd10, 4'd11: return P_X;
      4'd2, 4'd4, 4'd15:  return P_R;
      4'd3, 4'd6:         return P_RW;
      4'd5:               return P_RX;
      4'd7:               return P_RWX;
      default:            return P_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pmp_region_cmp.sv
module pmp_region_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              en,
  output logic              full,
  output logic              part
);
  logic in_first, in_last;
  always_comb begin
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b  >= lo) && (last_b  <= hi);
    full     = en && in_first && in_last;
    part     = en && (in_first ^ in_last);
  end
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     full,
  input  logic [N-1:0]     part,
  output logic             found,
  output logic             is_part,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found   = 1'b0;
    is_part = 1'b0;
    idx     = '0;
    // Descending walk: the lowest touching index is assigned last and wins
    for (int i = N - 1; i >= 0; i--) begin
      if (full[i] || part[i]) begin
        found   = 1'b1;
        is_part = part[i];
        idx     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pmp_grant.sv
module pmp_grant
  import pmp_pkg::*;
#(
  parameter int N       = 8,
  parameter int IDX_W   = 4,
  parameter bit HAS_PMP = 1'b1
) (
  input  logic             found,
  input  logic             is_part,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [CFG_W-1:0] win_cfg,
  input  logic             mmode,
  input  logic [2:0]       op,
  input  logic             lockdown,
  input  logic             deny_dflt,
  output perm_t            perm,
  output logic [IDX_W-1:0] idx,
  output logic             nomatch
);
  localparam logic [IDX_W-1:0] DFLT_IDX = IDX_W'(N);
  logic [3:0] key;
  assign key = win_cfg[3:0];

  always_comb begin
    perm    = P_NONE;
    idx     = '0;
    nomatch = 1'b0;
    if (found && is_part) begin
      nomatch = 1'b1;
    end else if (found) begin
      idx = win_idx;
      if (!lockdown)
        perm = (mmode && !win_cfg[CFG_LK]) ? P_RWX : perm_t'(win_cfg[2:0]);
      else
        perm = mmode ? lockdown_mach(key) : lockdown_low(key);
    end else if (deny_dflt) begin
      nomatch = 1'b1;
    end else if (lockdown) begin
      if (mmode && !op[0]) begin
        perm = P_RW;
        idx  = DFLT_IDX;
      end else begin
        nomatch = 1'b1;
      end
    end else if (mmode || !HAS_PMP) begin
      perm = P_RWX;
      idx  = DFLT_IDX;
    end else begin
      nomatch = 1'b1;
    end
  end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 4,
  parameter int WORD_BYTES  = 4,
  parameter bit HAS_PMP     = 1'b1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic                          req_mmode,
  input  logic [2:0]                    req_op,
  input  logic                          sec_lockdown,
  input  logic                          sec_deny_default,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input  logic [NUM_ENTRIES*5-1:0]      ent_cfg,
  output logic                          rsp_valid,
  output logic                          rsp_allow,
  output logic [2:0]                    rsp_perm,
  output logic [IDX_W-1:0]              rsp_idx,
  output logic                          rsp_nomatch
);
  logic [ADDR_W-1:0]      span, last_b;
  logic [NUM_ENTRIES-1:0] full, part;
  logic                   found, is_part;
  logic [IDX_W-1:0]       win_idx, g_idx;
  logic [CFG_W-1:0]       win_cfg;
  perm_t                  g_perm;
  logic                   g_nom, g_allow;

  assign span   = (req_size == '0) ? ADDR_W'(WORD_BYTES) : ADDR_W'(req_size);
  assign last_b = req_addr + span - ADDR_W'(1);

  generate
    if (HAS_PMP) begin : g_regions
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        pmp_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
          .first_b(req_addr),
          .last_b (last_b),
          .lo     (ent_lo[i*ADDR_W +: ADDR_W]),
          .hi     (ent_hi[i*ADDR_W +: ADDR_W]),
          .en     (ent_cfg[i*CFG_W + CFG_EN]),
          .full   (full[i]),
          .part   (part[i])
        );
      end
    end else begin : g_none
      assign full = '0;
      assign part = '0;
    end
  endgenerate

  pmp_prio_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_sel (
    .full(full), .part(part), .found(found), .is_part(is_part), .idx(win_idx)
  );

  always_comb begin
    win_cfg = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (win_idx == IDX_W'(i)) win_cfg = ent_cfg[i*CFG_W +: CFG_W];
  end

  pmp_grant #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .HAS_PMP(HAS_PMP)) u_grant (
    .found    (found),
    .is_part  (is_part),
    .win_idx  (win_idx),
    .win_cfg  (win_cfg),
    .mmode    (req_mmode),
    .op       (req_op),
    .lockdown (sec_lockdown),
    .deny_dflt(sec_deny_default),
    .perm     (g_perm),
    .idx      (g_idx),
    .nomatch  (g_nom)
  );

  assign g_allow = !g_nom && ((req_op & ~g_perm) == 3'b000);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_allow   <= 1'b0;
      rsp_perm    <= '0;
      rsp_idx     <= '0;
      rsp_nomatch <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow   <= g_allow;
        rsp_perm    <= g_perm;
        rsp_idx     <= g_idx;
        rsp_nomatch <= g_nom;
      end
    end
  end
endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_mmode,
  input logic [2:0]       req_op,
  input logic             sec_lockdown,
  input logic             sec_deny_default,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic [2:0]       rsp_perm,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             rsp_nomatch
);
  // R11: response valid tracks request valid one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R10: verdict consistent with the registered operation and grant
  a_r10_allow_subset: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_allow == (!rsp_nomatch && (($past(req_op) & ~rsp_perm) == 3'b000)));
  // R2: a deny flag carries no permissions
  a_r2_nomatch_empty: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_nomatch |-> rsp_perm == 3'b000 && rsp_idx == '0);
  // R7: the default index never appears under deny-by-default
  a_r7_no_default_grant: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(sec_deny_default) |-> rsp_idx != IDX_W'(NUM_ENTRIES));
  // R5: machine mode under lockdown never receives RWX
  a_r5_mach_no_rwx: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(sec_lockdown) && $past(req_mmode) |-> rsp_perm != 3'b111);
endmodule

bind pmp_perm_check pmp_perm_check_sva #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mmode(req_mmode), .req_op(req_op),
  .sec_lockdown(sec_lockdown), .sec_deny_default(sec_deny_default),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_perm(rsp_perm),
  .rsp_idx(rsp_idx), .rsp_nomatch(rsp_nomatch)
);

// File: tb/tb_pmp_perm_check.sv
module tb_pmp_perm_check;
  localparam int N = 8;
  localparam int AW = 32;
  localparam int IW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_mmode = 1'b0, lockdown = 1'b0, deny_dflt = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [2:0] req_op = '0;
  logic [N*AW-1:0] ent_lo, ent_hi;
  logic [N*5-1:0] ent_cfg;
  logic rsp_valid, rsp_allow, rsp_nomatch;
  logic [2:0] rsp_perm;
  logic [IW-1:0] rsp_idx;
  logic np_valid, np_allow, np_nomatch;
  logic [2:0] np_perm;
  logic [IW-1:0] np_idx;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmp_perm_check dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_mmode(req_mmode), .req_op(req_op), .sec_lockdown(lockdown), .sec_deny_default(deny_dflt),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_perm(rsp_perm),
    .rsp_idx(rsp_idx), .rsp_nomatch(rsp_nomatch));

  pmp_perm_check #(.HAS_PMP(1'b0)) dut_np (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_mmode(req_mmode), .req_op(req_op), .sec_lockdown(lockdown), .sec_deny_default(deny_dflt),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
    .rsp_valid(np_valid), .rsp_allow(np_allow), .rsp_perm(np_perm),
    .rsp_idx(np_idx), .rsp_nomatch(np_nomatch));

  // {lockdown, deny, mmode, addr32, size4, op3, exp_perm3, exp_idx4, exp_nom, exp_allow}
  localparam int VW = 51;
  localparam int NV = 20;
  localparam logic [VW-1:0] VECS [NV] = '{
    {3'b000, 32'h100,  4'd4, 3'b100, 3'b100, 4'd0, 1'b0, 1'b1}, // R1 R4 lower mode, R region
    {3'b000, 32'h100,  4'd4, 3'b010, 3'b100, 4'd0, 1'b0, 1'b0}, // R10 write not granted
    {3'b001, 32'h104,  4'd4, 3'b010, 3'b111, 4'd0, 1'b0, 1'b1}, // R4 mach unlocked RWX
    {3'b000, 32'h1FE,  4'd4, 3'b100, 3'b000, 4'd0, 1'b1, 1'b0}, // R2 straddle region0, region1 ignored
    {3'b000, 32'h200,  4'd4, 3'b010, 3'b110, 4'd1, 1'b0, 1'b1}, // R1 region1 only
    {3'b000, 32'h180,  4'd8, 3'b100, 3'b100, 4'd0, 1'b0, 1'b1}, // R1 lowest index wins
    {3'b001, 32'h1000, 4'd0, 3'b010, 3'b101, 4'd2, 1'b0, 1'b0}, // R4 locked mach gets bits
    {3'b001, 32'h1FFE, 4'd0, 3'b100, 3'b000, 4'd0, 1'b1, 1'b0}, // R3 size0 = 4 straddles
    {3'b001, 32'h1FFE, 4'd1, 3'b100, 3'b101, 4'd2, 1'b0, 1'b1}, // R3 size1 fits
    {3'b000, 32'h3000, 4'd4, 3'b100, 3'b000, 4'd0, 1'b1, 1'b0}, // R12 R9 disabled region, lower denied
    {3'b001, 32'h3000, 4'd4, 3'b001, 3'b111, 4'd8, 1'b0, 1'b1}, // R9 mach default RWX
    {3'b101, 32'h3000, 4'd4, 3'b100, 3'b110, 4'd8, 1'b0, 1'b1}, // R8 mach read RW
    {3'b101, 32'h3000, 4'd4, 3'b001, 3'b000, 4'd0, 1'b1, 1'b0}, // R8 mach exec denied
    {3'b100, 32'h3000, 4'd4, 3'b100, 3'b000, 4'd0, 1'b1, 1'b0}, // R8 lower denied
    {3'b011, 32'h3000, 4'd4, 3'b100, 3'b000, 4'd0, 1'b1, 1'b0}, // R7 mach denied
    {3'b101, 32'h100,  4'd4, 3'b100, 3'b000, 4'd0, 1'b0, 1'b0}, // R5 idx4 none
    {3'b100, 32'h100,  4'd4, 3'b100, 3'b100, 4'd0, 1'b0, 1'b1}, // R6 idx4 R
    {3'b010, 32'h200,  4'd4, 3'b010, 3'b110, 4'd1, 1'b0, 1'b1}, // R7 match unaffected
    {3'b101, 32'h1000, 4'd4, 3'b001, 3'b101, 4'd2, 1'b0, 1'b1}, // R5 idx13 RX
    {3'b100, 32'h1000, 4'd4, 3'b001, 3'b000, 4'd2, 1'b0, 1'b0}  // R6 idx13 none
  };

  function automatic logic [2:0] ref_mach(input int k);
    case (k)
      2, 3, 14: return 3'b110;
      9, 10:    return 3'b001;
      11, 13:   return 3'b101;
      12, 15:   return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] ref_low(input int k);
    case (k)
      7:         return 3'b111;
      3, 6:      return 3'b110;
      5:         return 3'b101;
      2, 4, 15:  return 3'b100;
      1, 10, 11: return 3'b001;
      default:   return 3'b000;
    endcase
  endfunction

  task automatic set_region(input int i, input logic [31:0] lo, input logic [31:0] hi,
                            input logic [4:0] cfg);
    ent_lo[i*AW +: AW] = lo;
    ent_hi[i*AW +: AW] = hi;
    ent_cfg[i*5 +: 5]  = cfg;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic ld, input logic dd, input logic mm, input logic [31:0] a,
                       input logic [3:0] s, input logic [2:0] op);
    lockdown = ld; deny_dflt = dd; req_mmode = mm;
    req_addr = a; req_size = s; req_op = op; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1'b1;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) set_region(i, 32'h0, 32'hFFFF_FFFF, 5'b00000);
    set_region(0, 32'h100,  32'h1FF,  5'b10100);
    set_region(1, 32'h180,  32'h27F,  5'b10110);
    set_region(2, 32'h1000, 32'h1FFF, 5'b11101);
    set_region(3, 32'h3000, 32'h3003, 5'b00111);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset valid", 32'(rsp_valid), 0);
    chk("R11 reset perm", 32'(rsp_perm), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VECS[v];
      issue(e[50], e[49], e[48], e[47:16], e[15:12], e[11:9]);
      chk($sformatf("R1 vec%0d valid", v), 32'(rsp_valid), 1);
      chk($sformatf("R1 vec%0d perm", v), 32'(rsp_perm), 32'(e[8:6]));
      chk($sformatf("R1 vec%0d idx", v), 32'(rsp_idx), 32'(e[5:2]));
      chk($sformatf("R2 vec%0d nomatch", v), 32'(rsp_nomatch), 32'(e[1]));
      chk($sformatf("R10 vec%0d allow", v), 32'(rsp_allow), 32'(e[0]));
    end

    // R9 without regions every mode is granted RWX at the default index
    issue(1'b0, 1'b0, 1'b0, 32'h100, 4'd4, 3'b010);
    chk("R9 no-region perm", 32'(np_perm), 32'h7);
    chk("R9 no-region idx", 32'(np_idx), N);
    chk("R9 no-region allow", 32'(np_allow), 1);

    // R5 R6 exhaustive lockdown table sweep on region 0
    for (int k = 0; k < 16; k++) begin
      set_region(0, 32'h100, 32'h1FF, {1'b1, 4'(k)});
      issue(1'b1, 1'b0, 1'b1, 32'h100, 4'd4, 3'b100);
      chk($sformatf("R5 key%0d", k), 32'(rsp_perm), 32'(ref_mach(k)));
      issue(1'b1, 1'b0, 1'b0, 32'h100, 4'd4, 3'b100);
      chk($sformatf("R6 key%0d", k), 32'(rsp_perm), 32'(ref_low(k)));
    end
    set_region(0, 32'h100, 32'h1FF, 5'b10100);

    // R11 idle cycle drops valid
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 idle valid", 32'(rsp_valid), 0);
    // R11 synchronous reset clears outputs
    issue(1'b0, 1'b0, 1'b1, 32'h104, 4'd4, 3'b100);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 reset allow", 32'(rsp_allow), 0);
    chk("R11 reset perm", 32'(rsp_perm), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule